// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned operands of `WIDTH` bits (eight by default) one multiplier bit per clock, least significant bit first. The double-width product lives in two registers of operand width, a high half and a low half. On each step the bit leaving the bottom of the multiplier register decides whether the multiplicand is added into the high half. The sum, with its carry out, is then shifted right by one place across carry, high half and low half together. The low half therefore fills from its top bit downward as the steps go by. After `WIDTH` steps the two halves hold the full product.

A caller presents both operands with a one-cycle `start`. The block accepts it only while `busy` is low. Acceptance clears both product halves and captures the operands, and `busy` is high for exactly `WIDTH` cycles. Because `busy` is high whenever a request would be refused, it is the back-pressure signal. A `start` raised while `busy` is high is dropped, not queued, so the caller must wait for `busy` to fall. `done` pulses for one cycle when the last step has completed. `done` carries no back-pressure: the product stays on the outputs until the next accepted `start`, and the caller may read it at any later time. A `start` in the same cycle as `done` is accepted at once.

Top module: `shmul_top`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `busy`, `done`, `prod_hi` and `prod_lo` are all zero.
- R2: A `start` sampled high while `busy` is low is accepted: `busy` is high on the next cycle and the operands on `mcand` and `mplier` at that edge are the ones multiplied.
- R3: Once raised, `busy` stays high for exactly `WIDTH` consecutive cycles.
- R4: On the cycle `busy` falls after a run, `{prod_hi, prod_lo}` equals the unsigned product of the captured operands, with `prod_hi` holding bits 2*WIDTH-1 down to WIDTH.
- R5: A `start` sampled while `busy` is high has no effect: the run in progress keeps its length and its operands, and it ends with their product.
- R6: While `busy` is low and no `start` is accepted, `prod_hi` and `prod_lo` keep their values.
- R7: An accepted `start` clears both product halves, so `{prod_hi, prod_lo}` reads zero on the first busy cycle.
- R8: `done` is high for exactly one cycle, the cycle on which `busy` falls, and at no other time.
- R9: After j of the steps (1 <= j <= WIDTH), `{prod_hi, prod_lo}` equals a * (x mod 2^j) * 2^(WIDTH-j), where a is the multiplicand and x is the multiplier.
- R10: Extreme operands give exact results: an operand of zero gives 0, and 255 * 255 gives 0xFE01 (high byte 0xFE, low byte 0x01).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a multiplication |
| mcand | input | WIDTH | Multiplicand, sampled on acceptance |
| mplier | input | WIDTH | Multiplier, sampled on acceptance |
| busy | output | 1 | High while a multiplication is running; a request is refused while high |
| done | output | 1 | One-cycle pulse when the product is complete |
| prod_hi | output | WIDTH | Upper half of the product |
| prod_lo | output | WIDTH | Lower half of the product |

## Verification
The assertions assume that reset is held long enough to clear every register. They also assume that `start`, `mcand` and `mplier` change only between clock edges, so each edge samples one settled request. The bench drives all inputs on the falling edge to meet this. Apart from that, it places `start` freely: in the middle of runs, on the `done` cycle, and held high for many cycles so that runs follow back to back. The refusal rule is therefore exercised and is not avoided by the stimulus.

// File: rtl/shmul_pkg.sv
package shmul_pkg;
  typedef enum logic [0:0] {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;
endpackage

// File: rtl/shmul_step.sv
module shmul_step #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] hi_cur,
  input  logic [WIDTH-1:0] lo_cur,
  input  logic [WIDTH-1:0] addend,
  input  logic             add_en,
  output logic [WIDTH-1:0] hi_nxt,
  output logic [WIDTH-1:0] lo_nxt
);
  localparam int SUM_W = WIDTH + 1;

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = {1'b0, hi_cur};
    if (add_en) sum = sum + {1'b0, addend};
    // shift right across carry, high half and low half
    hi_nxt = sum[SUM_W-1:1];
    lo_nxt = {sum[0], lo_cur[WIDTH-1:1]};
  end
endmodule

// File: rtl/shmul_ctrl.sv
module shmul_ctrl
  import shmul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  assign load = start && (phase_q == PH_IDLE);
  assign step = (phase_q == PH_RUN);
  assign busy = (phase_q == PH_RUN);
  assign done = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        phase_q <= PH_RUN;
        cnt_q   <= '0;
      end else if (step) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          phase_q <= PH_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  // R8: done never lasts two cycles
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R5: a request during a run does not restart the counter phase
  a_r5_no_reload: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |-> !load);
endmodule

// File: rtl/shmul_datapath.sv
module shmul_datapath #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [WIDTH-1:0] mcand,
  input  logic [WIDTH-1:0] mplier,
  output logic [WIDTH-1:0] hi,
  output logic [WIDTH-1:0] lo
);
  logic [WIDTH-1:0] mcand_q, mplier_q, hi_q, lo_q;
  logic [WIDTH-1:0] hi_nxt, lo_nxt;

  shmul_step #(.WIDTH(WIDTH)) u_step (
    .hi_cur (hi_q),
    .lo_cur (lo_q),
    .addend (mcand_q),
    .add_en (mplier_q[0]),
    .hi_nxt (hi_nxt),
    .lo_nxt (lo_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
    end else if (load) begin
      mcand_q  <= mcand;
      mplier_q <= mplier;
      hi_q     <= '0;
      lo_q     <= '0;
    end else if (step) begin
      mplier_q <= mplier_q >> 1;
      hi_q     <= hi_nxt;
      lo_q     <= lo_nxt;
    end
  end

  assign hi = hi_q;
  assign lo = lo_q;

  // R7: acceptance clears both halves
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    load |=> (hi == '0 && lo == '0));
  // R5: captured multiplicand is untouched while stepping
  a_r5_operand_kept: assert property (@(posedge clk) disable iff (rst)
    step |=> $stable(mcand_q));
  // R6: idle product holds
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> ($stable(hi) && $stable(lo)));
endmodule

// File: rtl/shmul_top.sv
module shmul_top #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] mcand,
  input  logic [WIDTH-1:0] mplier,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] prod_hi,
  output logic [WIDTH-1:0] prod_lo
);
  localparam int LEN_W = $clog2(WIDTH + 1) + 1;

  logic load, step;

  shmul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .load  (load),
    .step  (step),
    .busy  (busy),
    .done  (done)
  );

  shmul_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .step   (step),
    .mcand  (mcand),
    .mplier (mplier),
    .hi     (prod_hi),
    .lo     (prod_lo)
  );

  // run-length watch for the busy window
  logic [LEN_W-1:0] run_len;
  always_ff @(posedge clk) begin
    if (rst)       run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  // R2: an idle request starts a run
  a_r2_accept: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  // R3: busy lasts exactly WIDTH cycles
  a_r3_run_len: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == LEN_W'(WIDTH)));
  // R8: done marks the end of a run
  a_r8_done_at_fall: assert property (@(posedge clk) disable iff (rst)
    done |-> $fell(busy));
endmodule

// File: tb/shmul_top_bench.sv
module shmul_top_bench;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 5000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] mcand = '0, mplier = '0;
  logic busy, done;
  logic [W-1:0] prod_hi, prod_lo;

  int n_tests = 0;
  int n_fail = 0;
  int cycles = 0;

  shmul_top #(.WIDTH(W)) u_shmul_top (
    .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplier(mplier),
    .busy(busy), .done(done), .prod_hi(prod_hi), .prod_lo(prod_lo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  int  m_busy = 0, m_done = 0, m_j = 0, m_rst = 1;
  longint m_a = 0, m_x = 0, m_prod = 0;
  bit  m_interfered = 0;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_busy = 0; m_done = 0; m_j = 0; m_prod = 0; m_rst = 1;
      m_interfered = 0;
    end else begin
      m_rst = 0;
      m_done = 0;
      if (m_busy != 0) begin
        if (start) m_interfered = 1;
        m_j++;
        m_prod = (m_a * (m_x % (longint'(1) << m_j)) * 256) >> m_j;
        if (m_j == W) begin
          m_busy = 0;
          m_done = 1;
        end
      end else if (start) begin
        m_busy = 1; m_j = 0; m_a = mcand; m_x = mplier; m_prod = 0;
        m_interfered = 0;
      end
    end
  end

  task automatic check(string tag, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cycles > 0) begin
      string tb, tp;
      longint act;
      act = {prod_hi, prod_lo};
      if (m_rst != 0) begin
        tb = "R1"; tp = "R1";
      end else begin
        tb = (m_busy != 0 && m_j == 0) ? "R2" : "R3";
        if (m_done != 0) begin
          if (m_interfered) tp = "R5";
          else if (m_a == 0 || m_x == 0 || (m_a == 255 && m_x == 255)) tp = "R10";
          else tp = "R4";
        end else if (m_busy != 0 && m_j == 0) tp = "R7";
        else if (m_busy != 0) tp = "R9";
        else tp = "R6";
      end
      check(tb, busy, m_busy);
      check((m_rst != 0) ? "R1" : "R8", done, m_done);
      check(tp, act, m_prod);
    end
  end

  task automatic req(logic [W-1:0] a, logic [W-1:0] x);
    @(negedge clk);
    start = 1'b1; mcand = a; mplier = x;
    @(negedge clk);
    start = 1'b0; mcand = ~a; mplier = ~x;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    @(negedge clk) rst = 1'b0;
    idle(2);
    req(8'hD7, 8'h11); idle(10);      // R4
    req(8'h00, 8'h9D); idle(10);      // R10
    req(8'hFF, 8'hFF); idle(10);      // R10
    req(8'h5A, 8'h00); idle(10);      // R10
    // R5: request in mid-run with other operands
    req(8'h3C, 8'hA5); idle(2);
    start = 1'b1; mcand = 8'hFF; mplier = 8'hFF;
    idle(1); start = 1'b0; idle(10);
    // R6: inputs wiggle while idle, no start
    mcand = 8'h12; mplier = 8'h34; idle(3);
    // back-to-back runs with start held high (R2, R3, R8)
    @(negedge clk) start = 1'b1; mcand = 8'h81; mplier = 8'h7E;
    idle(30);
    start = 1'b0; idle(10);
    for (int k = 0; k < 20; k++) begin
      req(8'((k * 37 + 11) & 255), 8'((k * 91 + 3) & 255));
      idle(9 + (k % 3));
    end
    // R1: reset in mid-run
    req(8'hC3, 8'h5F); idle(3);
    @(negedge clk) rst = 1'b1;
    idle(2);
    @(negedge clk) rst = 1'b0;
    idle(3);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait (cycles > WATCHDOG);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule